// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART's serial output and turns every bit of value 0 into a short high pulse on the infrared transmit line. A bit of value 1, and an idle line, produce no light at all. The pulse is either three sixteenths of a bit period long, timed by the UART's 16x baud tick, or a fixed number of system clock cycles. The fixed length lets a short pulse of about 1.6 µs be kept at any of the usual rates from 2400 to 115200 bit/s.

On the receive side, each rising edge seen on the infrared receive line pulls the UART receive line low for one bit period, counted in 16x ticks. A bit period that holds a pulse thus reads as 0 and a bit period without one reads as 1. Frames are the UART's own: a 0 start bit, eight data bits sent LSB first, and a 1 stop bit. The block finds bit boundaries from the UART line itself and needs no framing knowledge. The UART framing logic and the baud generator are outside the block.

Top module: `ir_sir_codec`

## Requirements
- R1: While reset is asserted, ir_tx is low and uart_rxd is high.
- R2: With fixed_mode at 0, a bit of value 0 drives ir_tx high from the clock edge of the tick that starts the bit, for exactly 3 tick periods.
- R3: For a bit of value 1, ir_tx stays low for the whole bit period.
- R4: With fixed_mode at 1, a bit of value 0 drives ir_tx high from the clock edge of the tick that starts the bit, for fixed_len clock cycles. A fixed_len of 0 gives 1 cycle.
- R5: Whenever the UART line sampled at the last tick is high, ir_tx is low, even if a fixed pulse longer than the bit is still being timed.
- R6: A falling edge of uart_txd seen at a tick starts a bit period. Later bit periods start every 16 ticks after it, whatever the tick phase was before.
- R7: ir_rx passes through a two-flop synchronizer. After a rising edge on ir_rx, uart_rxd goes low at the third clock edge.
- R8: uart_rxd returns high at the 16th tick after it went low, and it changes to high only at a tick.
- R9: A new rising edge on ir_rx while uart_rxd is held low restarts the 16-tick hold.
- R10: With ir_tx looped back to ir_rx, sampling uart_rxd in the middle of each bit period gives back the frame sent on uart_txd (start 0, data LSB first, stop 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| fixed_mode | input | 1 | 0: pulse of 3/16 bit; 1: pulse of fixed_len clock cycles |
| fixed_len | input | LEN_W (12) | Length of the fixed pulse in clock cycles |
| uart_txd | input | 1 | Serial output of the UART, idle high |
| ir_rx | input | 1 | Pulse output of the infrared receiver, active high |
| ir_tx | output | 1 | Drive to the infrared emitter, active high |
| uart_rxd | output | 1 | Serial input to the UART, idle high |

## Verification
A transmit pulse starts on the clock edge that samples the bit's first tick. The bench therefore changes uart_txd on the falling clock edge just before a tick and counts the high cycles of ir_tx over the next 16 tick periods: 12 cycles for a 3-tick pulse at 4 clocks per tick, or the fixed length. On the receive side, three edges are due before uart_rxd falls: two synchronizer stages and the hold register. The bench drives ir_rx on a tick-aligned falling edge, expects the first low sample on the third falling edge after that, and expects the line to rise after the 16th tick that follows. In loopback, uart_rxd is sampled 32 cycles into each bit, well clear of both the transmit and the receive latency.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;
  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned RATIO_TICKS   = 3;
  localparam int unsigned SYNC_STAGES   = 2;

  typedef enum logic {
    PW_RATIO = 1'b0,
    PW_FIXED = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/ir_bit_phase.sv
module ir_bit_phase #(
  parameter int unsigned TPB = ir_sir_pkg::TICKS_PER_BIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd,
  output logic zero_start,
  output logic bit_val
);
  localparam int unsigned PW = $clog2(TPB);

  logic [PW-1:0] phase_q, phase_d;
  logic          txd_q, txd_d;
  logic          fall, wrap, bit_start;

  always_comb begin
    fall      = tick & txd_q & ~txd;
    wrap      = tick & (phase_q == PW'(TPB - 1));
    bit_start = fall | wrap;
    phase_d   = phase_q;
    txd_d     = txd_q;
    if (tick) begin
      phase_d = bit_start ? '0 : phase_q + 1'b1;
      txd_d   = txd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      txd_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      txd_q   <= txd_d;
    end
  end

  assign zero_start = bit_start & ~txd;
  assign bit_val    = txd_q;
endmodule

// File: rtl/ir_tx_pulse.sv
module ir_tx_pulse #(
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned PULSE_TICKS = ir_sir_pkg::RATIO_TICKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fire,
  input  logic             fixed_mode,
  input  logic [LEN_W-1:0] fixed_len,
  input  logic             bit_val,
  output logic             ir_tx
);
  import ir_sir_pkg::*;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;
  pw_mode_e         mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    on_d   = on_q;
    mode_d = mode_q;
    if (fire) begin
      on_d   = 1'b1;
      mode_d = fixed_mode ? PW_FIXED : PW_RATIO;
      if (fixed_mode)
        cnt_d = (fixed_len == '0) ? '0 : fixed_len - 1'b1;
      else
        cnt_d = '0;
    end else if (on_q) begin
      if (mode_q == PW_FIXED) begin
        if (cnt_q == '0) on_d  = 1'b0;
        else             cnt_d = cnt_q - 1'b1;
      end else if (tick) begin
        if (cnt_q == LEN_W'(PULSE_TICKS - 1)) on_d  = 1'b0;
        else                                  cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      on_q   <= 1'b0;
      mode_q <= PW_RATIO;
    end else begin
      cnt_q  <= cnt_d;
      on_q   <= on_d;
      mode_q <= mode_d;
    end
  end

  assign ir_tx = on_q & ~bit_val;
endmodule

// File: rtl/ir_sync.sv
module ir_sync #(
  parameter int unsigned STAGES = ir_sir_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b0;
          else        stg_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ir_rx_stretch.sv
module ir_rx_stretch #(
  parameter int unsigned HOLD = ir_sir_pkg::TICKS_PER_BIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic rxd
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q, left_d;
  logic          prev_q, rxd_q, rxd_d;
  logic          rise;

  always_comb begin
    rise   = din & ~prev_q;
    left_d = left_q;
    rxd_d  = rxd_q;
    if (rise) begin
      left_d = HW'(HOLD);
      rxd_d  = 1'b0;
    end else if (tick && left_q != '0) begin
      left_d = left_q - 1'b1;
      if (left_q == HW'(1)) rxd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      prev_q <= 1'b0;
      rxd_q  <= 1'b1;
    end else begin
      left_q <= left_d;
      prev_q <= din;
      rxd_q  <= rxd_d;
    end
  end

  assign rxd = rxd_q;
endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec #(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned TPB   = ir_sir_pkg::TICKS_PER_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             fixed_mode,
  input  logic [LEN_W-1:0] fixed_len,
  input  logic             uart_txd,
  input  logic             ir_rx,
  output logic             ir_tx,
  output logic             uart_rxd
);
  logic zero_start, bit_val, ir_rx_s;

  ir_bit_phase #(.TPB(TPB)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .txd(uart_txd),
    .zero_start(zero_start), .bit_val(bit_val)
  );

  ir_tx_pulse #(.LEN_W(LEN_W)) u_txp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fire(zero_start),
    .fixed_mode(fixed_mode), .fixed_len(fixed_len), .bit_val(bit_val),
    .ir_tx(ir_tx)
  );

  ir_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_rx), .dout(ir_rx_s)
  );

  ir_rx_stretch #(.HOLD(TPB)) u_rxs (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .din(ir_rx_s), .rxd(uart_rxd)
  );
endmodule

// File: rtl/ir_sir_checker.sv
module ir_sir_checker (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic uart_txd,
  input logic ir_rx,
  input logic ir_tx,
  input logic uart_rxd
);
  logic rst_seen = 1'b0;

  always @(posedge clk) if (!rst_n) rst_seen <= 1'b1;

  // R1
  always @(negedge clk) begin
    if (rst_seen && !rst_n)
      a_r1_reset_state: assert (!ir_tx && uart_rxd);
  end

  a_r2_pulse_on_zero_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> ($past(tick16) && !$past(uart_txd)));

  a_r5_one_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && uart_txd) |=> !ir_tx);

  a_r7_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_rx) |=> ##2 !uart_rxd);

  a_r8_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uart_rxd) |-> $past(tick16));
endmodule

bind ir_sir_codec ir_sir_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .uart_txd(uart_txd),
  .ir_rx(ir_rx), .ir_tx(ir_tx), .uart_rxd(uart_rxd)
);

// File: tb/tb_ir_sir_codec.sv
module tb_ir_sir_codec;
  localparam int LEN_W   = 12;
  localparam int TDIV    = 4;
  localparam int BIT_CYC = 16 * TDIV;
  localparam int NVEC    = 6;
  // {fixed_mode, fixed_len, data byte}
  localparam logic [20:0] VEC [0:NVEC-1] = '{
    {1'b0, 12'd0,  8'h55},
    {1'b0, 12'd0,  8'h00},
    {1'b0, 12'd0,  8'hFF},
    {1'b1, 12'd7,  8'hA5},
    {1'b1, 12'd20, 8'h3C},
    {1'b1, 12'd1,  8'h81}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fixed_mode = 1'b0;
  logic [LEN_W-1:0] fixed_len = '0;
  logic             uart_txd = 1'b1;
  logic             ir_drv = 1'b0;
  logic             loop_en = 1'b0;
  logic             ir_rx, ir_tx, uart_rxd, tick16;
  int               cyc = 0;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick16 = (cyc % TDIV) == 0;
  assign ir_rx  = loop_en ? ir_tx : ir_drv;

  ir_sir_codec #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .fixed_mode(fixed_mode),
    .fixed_len(fixed_len), .uart_txd(uart_txd), .ir_rx(ir_rx),
    .ir_tx(ir_tx), .uart_rxd(uart_rxd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic align();
    while (!tick16) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output int hi, output logic mid);
    align();
    uart_txd = b;
    hi = 0;
    mid = 1'b1;
    for (int k = 1; k <= BIT_CYC; k++) begin
      @(negedge clk);
      if (ir_tx) hi++;
      if (k == BIT_CYC / 2) mid = uart_rxd;
    end
  endtask

  task automatic rx_pulse_test(input int second_at, output int first_low, output int low_cnt);
    align();
    ir_drv = 1'b1;
    first_low = -1;
    low_cnt = 0;
    for (int k = 1; k <= 140; k++) begin
      @(negedge clk);
      if (k == 2) ir_drv = 1'b0;
      if (k == second_at) ir_drv = 1'b1;
      if (k == second_at + 2) ir_drv = 1'b0;
      if (!uart_rxd) begin
        low_cnt++;
        if (first_low < 0) first_low = k;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, fl, lc, exp_hi, gap;
    logic mid;
    logic [9:0] frame, got;

    repeat (3) @(negedge clk);
    check(!ir_tx, "R1 ir_tx in reset", int'(ir_tx), 0);
    check(uart_rxd, "R1 uart_rxd in reset", int'(uart_rxd), 1);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R7, R8: single pulse
    rx_pulse_test(1000, fl, lc);
    check(fl == 3, "R7 first low sample", fl, 3);
    check(lc == 62, "R8 low cycles", lc, 62);
    // R9: retrigger after 8 ticks
    rx_pulse_test(32, fl, lc);
    check(lc == 94, "R9 retriggered low cycles", lc, 94);

    // R5: idle line keeps ir_tx low
    hi = 0;
    for (int k = 0; k < 40 * TDIV; k++) begin
      @(negedge clk);
      if (ir_tx) hi++;
    end
    check(hi == 0, "R5 idle high cycles", hi, 0);

    // vector table: R2, R3, R4, R6, R10
    loop_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      fixed_mode = VEC[i][20];
      fixed_len  = VEC[i][19:8];
      gap = 3 + i * 5;
      repeat (gap * TDIV + i) @(negedge clk);
      frame = {1'b1, VEC[i][7:0], 1'b0};
      exp_hi = fixed_mode ? ((fixed_len == 0) ? 1 : int'(fixed_len)) : 3 * TDIV;
      for (int b = 0; b < 10; b++) begin
        send_bit(frame[b], hi, mid);
        got[b] = mid;
        if (frame[b])
          check(hi == 0, "R3 one bit high cycles", hi, 0);
        else
          check(hi == exp_hi, fixed_mode ? "R4 fixed pulse cycles" : "R2 R6 ratio pulse cycles",
                hi, exp_hi);
      end
      uart_txd = 1'b1;
      check(got == frame, "R10 loopback frame", int'(got), int'(frame));
    end
    loop_en = 1'b0;
    repeat (40 * TDIV) @(negedge clk);

    // R5: fixed pulse longer than a bit is cut at the one bit
    fixed_mode = 1'b1;
    fixed_len  = 12'd100;
    send_bit(1'b0, hi, mid);
    check(hi == BIT_CYC, "R5 long pulse in zero bit", hi, BIT_CYC);
    send_bit(1'b1, hi, mid);
    check(hi == 0, "R5 long pulse cut in one bit", hi, 0);
    repeat (4 * BIT_CYC) @(negedge clk);

    // R4: zero length behaves as one cycle
    fixed_len = 12'd0;
    send_bit(1'b0, hi, mid);
    check(hi == 1, "R4 zero length pulse", hi, 1);
    send_bit(1'b1, hi, mid);
    check(hi == 0, "R3 one bit after short pulse", hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule